// File: doc/BRIEF.md
# Victim Buffer Controller for an Exclusive L1/L2 Pair

This block is a small, fully associative store placed between a level-one data cache and a level-two cache that never hold the same line at once. Every line pushed out of L1 lands here first. When L1 misses, the block sends the read to L2 in the same cycle it takes in L1's outgoing line, so storing that line overlaps the L2 access. The block compares the missed address against every held line, and against a line being evicted in the same cycle. On a match it returns that line to L1 one cycle later and throws away the L2 answer for that request.

When all entries are occupied, the oldest line is offered to L2 on a writeback port. Until L2 takes that line, new evictions are held off. A line that L2 returns on a miss goes only to L1: this block never stores it and never writes it back. Addresses on every port are line addresses, meaning a byte address with its six offset bits dropped, and one line is 64 bytes (512 bits).

Top module: `victim_buf`

## Requirements
- R1: An accepted eviction is stored in the buffer and does not appear on the writeback port while the buffer holds fewer than DEPTH lines.
- R2: When an eviction and a miss are both presented, they are accepted in the same cycle, and the L2 read request (l2RdValid high with l2RdReady high, l2RdAddr = missAddr) is issued in that same cycle.
- R3: A miss whose address matches a buffered line gives rspValid=1, rspFromBuf=1 and the buffered data in the cycle after acceptance. The L2 response for that miss produces no rspValid.
- R4: A buffered line that is returned on a hit is removed, so a second miss to that address is not answered from the buffer.
- R5: DEPTH (number of lines, 8 to 16, default 8), ADDR_W and LINE_W are parameters. No two valid entries ever hold the same address.
- R6: Once DEPTH lines are held, wbValid rises with the oldest line on wbAddr/wbData. These stay stable until wbReady, and one line leaves per full event, oldest first, even after a line has been removed from the middle.
- R7: While DEPTH lines are held, evReady is 0. It returns to 1 once the writeback handshake completes.
- R8: A miss that matches the line currently offered on the writeback port is answered from the buffer. That line stays offered until L2 accepts it and is gone afterwards.
- R9: An eviction and a miss to the same address in the same cycle return the evicted data to L1 (rspFromBuf=1), and the line is not stored.
- R10: A miss that does not match goes to L2. The block returns l2RspData with rspFromBuf=0 one cycle after l2RspValid, and writes nothing to the buffer or the writeback port.
- R11: After reset, rspValid=0, wbValid=0, evReady=1 and missReady=1 while L2 is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evValid | input | 1 | L1 eviction offered |
| evReady | output | 1 | Eviction accepted |
| evAddr | input | ADDR_W | Evicted line address |
| evData | input | LINE_W | Evicted line data |
| missValid | input | 1 | L1 miss lookup offered |
| missReady | output | 1 | Miss accepted |
| missAddr | input | ADDR_W | Missed line address |
| rspValid | output | 1 | Fill data to L1 valid |
| rspFromBuf | output | 1 | Fill came from the buffer |
| rspData | output | LINE_W | Fill data to L1 |
| l2RdValid | output | 1 | L2 read request |
| l2RdReady | input | 1 | L2 accepts read |
| l2RdAddr | output | ADDR_W | L2 read address |
| l2RspValid | input | 1 | L2 read data valid |
| l2RspData | input | LINE_W | L2 read data |
| wbValid | output | 1 | Writeback to L2 offered |
| wbReady | input | 1 | L2 accepts writeback |
| wbAddr | output | ADDR_W | Writeback line address |
| wbData | output | LINE_W | Writeback line data |

## Verification
The bench checks a miss that targets the line being evicted in the same cycle. A design without the forwarding path would send that miss to L2 and return stale data, or store a line that L1 is taking back. It looks up the line offered on the writeback port while L2 stalls, and then looks it up again after L2 accepts it. A design that drops the entry too early would lose the data, and one that drops it too late would answer from the buffer twice. It removes a line from the middle of a full-then-drained buffer and checks that the next drain still presents the oldest line, which catches compaction that reorders entries. It also checks that the L2 answer to a request already served from the buffer is discarded and does not reach L1 as a second fill.

// File: rtl/vb_pkg.sv
package vb_pkg;
  localparam int LINE_BYTES  = 64;
  localparam int OFFSET_BITS = $clog2(LINE_BYTES);
  localparam int LINE_BITS   = LINE_BYTES * 8;

  // strobes from control to the entry store
  typedef struct packed {
    logic push;     // append evicted line
    logic popHead;  // oldest line accepted by L2
    logic dropHit;  // remove the matching line
  } vbStrobe_t;
endpackage

// File: rtl/vb_store.sv
module vb_store
  import vb_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int DEPTH  = 8,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vbStrobe_t         strb,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [LINE_W-1:0] pushData,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic              hit,
  output logic              hitHead,
  output logic [LINE_W-1:0] hitData,
  output logic              full,
  output logic [ADDR_W-1:0] headAddr,
  output logic [LINE_W-1:0] headData
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IW    = $clog2(DEPTH);

  logic [ADDR_W-1:0] tagQ  [DEPTH];
  logic [LINE_W-1:0] lineQ [DEPTH];
  logic [ADDR_W-1:0] tagN  [DEPTH];
  logic [LINE_W-1:0] lineN [DEPTH];
  logic [DEPTH-1:0]  vldQ, vldN, match;
  logic [CNT_W-1:0]  count;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vldQ[g] && (tagQ[g] == lookAddr);
  end

  always_comb begin
    hitData = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match[i]) hitData = hitData | lineQ[i];
  end

  assign hit      = |match;
  assign hitHead  = match[0];
  assign count    = CNT_W'($countones(vldQ));
  assign full     = (count == CNT_W'(DEPTH));
  assign headAddr = tagQ[0];
  assign headData = lineQ[0];

  // survivors slide toward index 0, keeping age order; new line goes last
  always_comb begin
    logic [CNT_W-1:0] k;
    tagN  = tagQ;
    lineN = lineQ;
    vldN  = '0;
    k     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vldQ[i] && !(strb.popHead && i == 0) && !(strb.dropHit && match[i])) begin
        tagN[k[IW-1:0]]  = tagQ[i];
        lineN[k[IW-1:0]] = lineQ[i];
        vldN[k[IW-1:0]]  = 1'b1;
        k = k + CNT_W'(1);
      end
    end
    if (strb.push && k < CNT_W'(DEPTH)) begin
      tagN[k[IW-1:0]]  = pushAddr;
      lineN[k[IW-1:0]] = pushData;
      vldN[k[IW-1:0]]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vldQ <= '0;
    else        vldQ <= vldN;

  always_ff @(posedge clk) begin
    tagQ  <= tagN;
    lineQ <= lineN;
  end

  // R5
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // R7
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.push |-> !full);
  // R6
  head_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vldQ[0] && !strb.popHead && !strb.dropHit) |=> (vldQ[0] && $stable(headAddr)));
endmodule

// File: rtl/vb_ctrl.sv
module vb_ctrl
  import vb_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evValid,
  output logic              evReady,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [LINE_W-1:0] evData,
  input  logic              missValid,
  output logic              missReady,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              rspValid,
  output logic              rspFromBuf,
  output logic [LINE_W-1:0] rspData,
  output logic              l2RdValid,
  input  logic              l2RdReady,
  input  logic              l2RspValid,
  input  logic [LINE_W-1:0] l2RspData,
  output logic              wbValid,
  input  logic              wbReady,
  input  logic              full,
  input  logic              hit,
  input  logic              hitHead,
  input  logic [LINE_W-1:0] hitData,
  output vbStrobe_t         strb
);
  logic busyQ, discardQ, wbHoldQ;
  logic missOpen, pathOpen, missFire, evFire, fwd, bufHit;

  assign missOpen  = !busyQ && l2RdReady;
  assign pathOpen  = !evValid || !full;
  assign l2RdValid = missValid && !busyQ && pathOpen;
  assign missReady = missOpen && pathOpen;
  assign evReady   = !full && (!missValid || missOpen);

  assign missFire = missValid && missReady;
  assign evFire   = evValid && evReady;
  assign fwd      = missFire && evFire && (evAddr == missAddr);
  assign bufHit   = missFire && hit && !fwd;
  assign wbValid  = full || wbHoldQ;

  always_comb begin
    strb.push    = evFire && !fwd;
    strb.popHead = wbValid && wbReady;
    strb.dropHit = bufHit && !(hitHead && wbValid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ      <= 1'b0;
      discardQ   <= 1'b0;
      wbHoldQ    <= 1'b0;
      rspValid   <= 1'b0;
      rspFromBuf <= 1'b0;
      rspData    <= '0;
    end else begin
      wbHoldQ  <= wbValid && !wbReady;
      rspValid <= 1'b0;
      if (missFire) begin
        busyQ    <= 1'b1;
        discardQ <= fwd || bufHit;
        if (fwd || bufHit) begin
          rspValid   <= 1'b1;
          rspFromBuf <= 1'b1;
          rspData    <= fwd ? evData : hitData;
        end
      end else if (busyQ && l2RspValid) begin
        busyQ <= 1'b0;
        if (!discardQ) begin
          rspValid   <= 1'b1;
          rspFromBuf <= 1'b0;
          rspData    <= l2RspData;
        end
      end
    end
  end

  // R2
  pair_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evFire && missValid) |-> (l2RdValid && l2RdReady));
  // R3
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (missFire && hit) |=> (rspValid && rspFromBuf));
  // R3
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && discardQ && l2RspValid) |=> !rspValid);
  // R10
  l2_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && !discardQ && l2RspValid) |=> (rspValid && !rspFromBuf));
endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import vb_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int DEPTH  = 8,
  parameter int LINE_W = LINE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evValid,
  output logic              evReady,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [LINE_W-1:0] evData,
  input  logic              missValid,
  output logic              missReady,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              rspValid,
  output logic              rspFromBuf,
  output logic [LINE_W-1:0] rspData,
  output logic              l2RdValid,
  input  logic              l2RdReady,
  output logic [ADDR_W-1:0] l2RdAddr,
  input  logic              l2RspValid,
  input  logic [LINE_W-1:0] l2RspData,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [LINE_W-1:0] wbData
);
  vbStrobe_t         strb;
  logic              full, hit, hitHead;
  logic [LINE_W-1:0] hitData;

  assign l2RdAddr = missAddr;

  vb_ctrl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .evValid(evValid), .evReady(evReady), .evAddr(evAddr), .evData(evData),
    .missValid(missValid), .missReady(missReady), .missAddr(missAddr),
    .rspValid(rspValid), .rspFromBuf(rspFromBuf), .rspData(rspData),
    .l2RdValid(l2RdValid), .l2RdReady(l2RdReady),
    .l2RspValid(l2RspValid), .l2RspData(l2RspData),
    .wbValid(wbValid), .wbReady(wbReady),
    .full(full), .hit(hit), .hitHead(hitHead), .hitData(hitData),
    .strb(strb)
  );

  vb_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LINE_W(LINE_W)) store_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .pushAddr(evAddr), .pushData(evData), .lookAddr(missAddr),
    .hit(hit), .hitHead(hitHead), .hitData(hitData), .full(full),
    .headAddr(wbAddr), .headData(wbData)
  );

  // R6
  wb_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbAddr) && $stable(wbData)));
  // R1
  wb_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wbValid) |-> full);
endmodule

// File: tb/victim_buf_tb_top.sv
module victim_buf_tb_top;
  localparam int AW = 34;
  localparam int LW = 512;
  localparam int DP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evValid = 0, missValid = 0, l2RdReady = 1, l2RspValid = 0, wbReady = 0;
  logic [AW-1:0] evAddr = '0, missAddr = '0;
  logic [LW-1:0] evData = '0, l2RspData = '0;
  logic evReady, missReady, rspValid, rspFromBuf, l2RdValid, wbValid;
  logic [LW-1:0] rspData, wbData;
  logic [AW-1:0] l2RdAddr, wbAddr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  victim_buf #(.ADDR_W(AW), .DEPTH(DP), .LINE_W(LW)) dut_i (.*);

  function automatic logic [LW-1:0] lineOf(input logic [AW-1:0] a);
    logic [LW-1:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = {a[27:0], 4'(i)};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one miss, optionally with an eviction; returns pre-edge view
  task automatic doMiss(input logic [AW-1:0] a, input bit withEv, input logic [AW-1:0] ea,
                        output bit rdPre, output bit accPre);
    @(negedge clk);
    missValid = 1; missAddr = a;
    evValid = withEv; evAddr = ea; evData = lineOf(ea);
    #1;
    rdPre  = l2RdValid && (l2RdAddr == a);
    accPre = missReady && (!withEv || evReady);
    @(posedge clk);
    @(negedge clk);
    missValid = 0; evValid = 0;
  endtask

  task automatic l2Reply(input logic [LW-1:0] d);
    @(negedge clk);
    l2RspValid = 1; l2RspData = d;
    @(posedge clk);
    @(negedge clk);
    l2RspValid = 0;
  endtask

  task automatic pushEv(input logic [AW-1:0] a, output bit rdy);
    @(negedge clk);
    evValid = 1; evAddr = a; evData = lineOf(a);
    #1 rdy = evReady;
    @(posedge clk);
    @(negedge clk);
    evValid = 0;
  endtask

  task automatic t_reset();
    chk(!rspValid, "R11 rspValid", 64'(rspValid), 0);
    chk(!wbValid, "R11 wbValid", 64'(wbValid), 0);
    chk(evReady, "R11 evReady", 64'(evReady), 1);
    chk(missReady, "R11 missReady", 64'(missReady), 1);
  endtask

  task automatic t_l2Miss();
    bit rd, acc;
    doMiss(34'd100, 0, '0, rd, acc);
    chk(rd && acc, "R10 read issued", 64'(rd), 1);
    chk(!rspValid, "R10 no early rsp", 64'(rspValid), 0);
    l2Reply(~lineOf(34'd100));
    chk(rspValid && !rspFromBuf, "R10 fill from L2", {62'd0, rspValid, rspFromBuf}, 64'h2);
    chk(rspData == ~lineOf(34'd100), "R10 fill data", rspData[63:0], ~lineOf(34'd100) & 64'hFFFFFFFFFFFFFFFF);
    chk(!wbValid, "R10 no writeback", 64'(wbValid), 0);
  endtask

  task automatic t_pair();
    bit rd, acc;
    doMiss(34'd300, 1, 34'd200, rd, acc);
    chk(rd && acc, "R2 same-cycle read", {62'd0, rd, acc}, 64'h3);
    chk(!rspValid, "R2 miss not hit", 64'(rspValid), 0);
    chk(!wbValid, "R1 eviction not sent to L2", 64'(wbValid), 0);
    l2Reply(~lineOf(34'd300));
    chk(rspValid && !rspFromBuf, "R2 fill from L2", 64'(rspFromBuf), 0);
  endtask

  task automatic t_hit();
    bit rd, acc;
    doMiss(34'd200, 0, '0, rd, acc);
    chk(rspValid && rspFromBuf, "R3 hit rsp", {62'd0, rspValid, rspFromBuf}, 64'h3);
    chk(rspData == lineOf(34'd200), "R3 hit data", rspData[63:0], lineOf(34'd200) & 64'hFFFFFFFFFFFFFFFF);
    l2Reply(~lineOf(34'd200));
    chk(!rspValid, "R3 L2 rsp discarded", 64'(rspValid), 0);
    doMiss(34'd200, 0, '0, rd, acc);
    chk(!rspValid, "R4 entry removed", 64'(rspValid), 0);
    l2Reply(~lineOf(34'd200));
    chk(rspValid && !rspFromBuf, "R4 second miss from L2", 64'(rspFromBuf), 0);
  endtask

  task automatic t_forward();
    bit rd, acc;
    doMiss(34'd400, 1, 34'd400, rd, acc);
    chk(rspValid && rspFromBuf, "R9 forwarded", {62'd0, rspValid, rspFromBuf}, 64'h3);
    chk(rspData == lineOf(34'd400), "R9 forward data", rspData[63:0], lineOf(34'd400) & 64'hFFFFFFFFFFFFFFFF);
    l2Reply(~lineOf(34'd400));
    chk(!rspValid, "R9 L2 rsp discarded", 64'(rspValid), 0);
    doMiss(34'd400, 0, '0, rd, acc);
    chk(!rspValid, "R9 line not stored", 64'(rspValid), 0);
    l2Reply(~lineOf(34'd400));
  endtask

  task automatic t_fill();
    bit rdy, rd, acc;
    for (int i = 0; i < DP; i++) begin
      pushEv(34'(500 + i), rdy);
      chk(rdy, "R1 eviction accepted", 64'(rdy), 1);
      if (i < DP - 1) chk(!wbValid, "R1 no drain below full", 64'(wbValid), 0);
    end
    chk(wbValid && wbAddr == 34'd500, "R6 oldest offered", 64'(wbAddr), 64'd500);
    chk(wbData == lineOf(34'd500), "R6 drain data", wbData[63:0], lineOf(34'd500) & 64'hFFFFFFFFFFFFFFFF);
    chk(!evReady, "R7 full stalls evictions", 64'(evReady), 0);
    evValid = 1; evAddr = 34'd600; evData = lineOf(34'd600);
    repeat (2) @(negedge clk);
    chk(!evReady, "R7 still stalled", 64'(evReady), 0);
    chk(wbValid && wbAddr == 34'd500, "R6 drain held stable", 64'(wbAddr), 64'd500);
    evValid = 0;
    doMiss(34'd500, 0, '0, rd, acc);
    chk(rspValid && rspFromBuf, "R8 in-flight hit", {62'd0, rspValid, rspFromBuf}, 64'h3);
    chk(rspData == lineOf(34'd500), "R8 in-flight data", rspData[63:0], lineOf(34'd500) & 64'hFFFFFFFFFFFFFFFF);
    chk(wbValid && wbAddr == 34'd500, "R8 still offered", 64'(wbAddr), 64'd500);
    l2Reply(~lineOf(34'd500));
    wbReady = 1;
    @(posedge clk);
    @(negedge clk);
    wbReady = 0;
    chk(!wbValid, "R6 one line per full event", 64'(wbValid), 0);
    chk(evReady, "R7 ready after writeback", 64'(evReady), 1);
    doMiss(34'd500, 0, '0, rd, acc);
    chk(!rspValid, "R8 gone after writeback", 64'(rspValid), 0);
    l2Reply(~lineOf(34'd500));
    doMiss(34'd503, 0, '0, rd, acc);
    chk(rspValid && rspData == lineOf(34'd503), "R4 middle hit", 64'(rspValid), 1);
    l2Reply(~lineOf(34'd503));
    pushEv(34'd600, rdy);
    pushEv(34'd601, rdy);
    chk(wbValid && wbAddr == 34'd501, "R6 oldest first after removal", 64'(wbAddr), 64'd501);
    wbReady = 1;
    @(posedge clk);
    @(negedge clk);
    wbReady = 0;
    doMiss(34'd504, 0, '0, rd, acc);
    chk(rspValid && rspData == lineOf(34'd504), "R5 order kept", rspData[63:0], lineOf(34'd504) & 64'hFFFFFFFFFFFFFFFF);
    l2Reply(~lineOf(34'd504));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_l2Miss();
    t_pair();
    t_hit();
    t_forward();
    t_fill();
    repeat (2) @(negedge clk);
    finish();
  end
endmodule